// File: doc/BRIEF.md
# Hardware Test-And-Set Semaphore Unit

This block keeps a bank of one-bit semaphores that several processors share. A semaphore holding one means some processor has claimed the guarded critical section and the resource is busy. A semaphore holding zero means the resource is free. A processor claims a semaphore with an atomic test-and-set. The unit reports the value the bit held before the operation and leaves the bit at one, and no other operation can reach any semaphore between that read and that write. The processor may enter its critical section only if the reported value was zero. When it leaves, it issues a clear.

Each processor has its own request lane, made of a valid bit, a two-bit operation code and a semaphore index. A processor keeps its request asserted until it sees its response pulse, and it withdraws the request before the next clock edge. When several lanes request in the same cycle, the unit carries out one operation per cycle and always picks the lowest-numbered eligible lane. A lane is not eligible in the cycle right after it was served.

Top module: `sem_unit`

## Requirements
- R1: After reset every semaphore reads zero and no response pulse is raised.
- R2: Op code 01 (test-and-set) on a semaphore holding zero returns 0 and leaves the semaphore at one.
- R3: Test-and-set on a semaphore already holding one returns 1 and the semaphore stays at one.
- R4: Op code 10 (clear) returns the value held before the operation and leaves the semaphore at zero.
- R5: A clear on a semaphore already at zero returns 0 and leaves it at zero.
- R6: Op code 00 (read) returns the current value and does not change it.
- R7: Op code 11 behaves as a read: it returns the current value and changes no semaphore.
- R8: When several lanes request together, they are served one per cycle, lowest lane index first. A lane is skipped in the cycle after it was served.
- R9: A response is a single-cycle pulse on the rsp_valid bit of the served lane only, raised in the cycle after the edge that accepted the request. The lane's rsp_data bit carries the returned value.
- R10: An operation on one semaphore index leaves every other semaphore unchanged, up to and including the highest index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | N_CPU | Per-lane request valid |
| req_op | input | 2*N_CPU | Per-lane op code; lane k at bits [2k+1:2k] |
| req_idx | input | N_CPU*IDX_W | Per-lane semaphore index; lane k at bits [k*IDX_W +: IDX_W] |
| rsp_valid | output | N_CPU | Per-lane single-cycle response pulse |
| rsp_data | output | N_CPU | Per-lane returned semaphore value, meaningful with rsp_valid |

## Verification
A table of single-lane operations walks one semaphore through every transition: free to claimed, claimed and claimed again, released, released again, and untouched under read and under the spare code. It also uses the highest index, so a mismatch points to the operation whose old-value or new-value rule is wrong. Four lanes then race a test-and-set on the same fresh semaphore. Only lane 0 may see zero, and the order of the pulses shows whether the fixed priority and the served-lane skip hold. A second race on two different semaphores separates the priority order from the semaphore contents, and a full sweep after reset confirms that all bits start clear.

// File: rtl/sem_pkg.sv
package sem_pkg;

    typedef enum logic [1:0] {
        OP_READ  = 2'b00,
        OP_TAS   = 2'b01,
        OP_CLEAR = 2'b10,
        OP_SPARE = 2'b11
    } sem_op_e;

endpackage

// File: rtl/sem_arbiter.sv
module sem_arbiter #(
    parameter int N_CPU = 4,
    parameter int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CPU-1:0] req,
    output logic [N_CPU-1:0] grant,
    output logic [CPU_W-1:0] grant_idx
);

    typedef struct packed {
        logic [N_CPU-1:0] served;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [N_CPU-1:0] eligible;
    logic [N_CPU:0]   lower_seen;

    assign eligible      = req & ~st_q.served;
    assign lower_seen[0] = 1'b0;

    for (genvar i = 0; i < N_CPU; i++) begin : g_prio
        assign grant[i]        = eligible[i] & ~lower_seen[i];
        assign lower_seen[i+1] = lower_seen[i] | eligible[i];
    end

    always_comb begin
        grant_idx = '0;
        for (int k = N_CPU - 1; k >= 0; k--) begin
            if (grant[k]) grant_idx = CPU_W'(k);
        end
        st_d        = st_q;
        st_d.served = grant;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R8
    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> (|(grant & req))); // R8
    AST_NO_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |=> ((grant & $past(grant)) == '0)); // R8

endmodule

// File: rtl/sem_array.sv
module sem_array
    import sem_pkg::*;
#(
    parameter int N_SEM = 16,
    parameter int IDX_W = $clog2(N_SEM)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_fire,
    input  sem_op_e          op_code,
    input  logic [IDX_W-1:0] op_idx,
    output logic             old_val
);

    typedef struct packed {
        logic [N_SEM-1:0] bits;
    } sem_state_t;

    sem_state_t st_d, st_q;
    logic       idx_ok;

    assign idx_ok = (int'(op_idx) < N_SEM);

    always_comb begin
        st_d    = st_q;
        old_val = idx_ok ? st_q.bits[op_idx] : 1'b0;
        if (op_fire && idx_ok) begin
            unique case (op_code)
                OP_TAS:   st_d.bits[op_idx] = 1'b1;
                OP_CLEAR: st_d.bits[op_idx] = 1'b0;
                default:  st_d.bits[op_idx] = st_q.bits[op_idx];
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TAS_LEAVES_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fire && op_code == OP_TAS && idx_ok) |=> st_q.bits[$past(op_idx)]); // R2
    AST_CLEAR_LEAVES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fire && op_code == OP_CLEAR && idx_ok) |=> !st_q.bits[$past(op_idx)]); // R4
    AST_READ_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_fire && (op_code == OP_READ || op_code == OP_SPARE)) |=> $stable(st_q.bits)); // R6
    AST_ONE_BIT_PER_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_d.bits ^ st_q.bits) <= 1); // R10

endmodule

// File: rtl/sem_unit.sv
module sem_unit
    import sem_pkg::*;
#(
    parameter int N_CPU = 4,
    parameter int N_SEM = 16,
    parameter int IDX_W = $clog2(N_SEM)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [N_CPU-1:0]       req_valid,
    input  logic [2*N_CPU-1:0]     req_op,
    input  logic [N_CPU*IDX_W-1:0] req_idx,
    output logic [N_CPU-1:0]       rsp_valid,
    output logic [N_CPU-1:0]       rsp_data
);

    localparam int CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1;

    typedef struct packed {
        logic [N_CPU-1:0] valid;
        logic [N_CPU-1:0] data;
    } rsp_state_t;

    rsp_state_t       rsp_d, rsp_q;
    logic [N_CPU-1:0] grant;
    logic [CPU_W-1:0] grant_idx;
    logic             op_fire;
    sem_op_e          sel_op;
    logic [IDX_W-1:0] sel_idx;
    logic             old_val;

    sem_arbiter #(.N_CPU(N_CPU), .CPU_W(CPU_W)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req_valid),
        .grant     (grant),
        .grant_idx (grant_idx)
    );

    always_comb begin
        op_fire = |grant;
        sel_op  = sem_op_e'(req_op[grant_idx*2 +: 2]);
        sel_idx = req_idx[grant_idx*IDX_W +: IDX_W];
    end

    sem_array #(.N_SEM(N_SEM), .IDX_W(IDX_W)) u_sems (
        .clk     (clk),
        .rst_n   (rst_n),
        .op_fire (op_fire),
        .op_code (sel_op),
        .op_idx  (sel_idx),
        .old_val (old_val)
    );

    always_comb begin
        rsp_d       = rsp_q;
        rsp_d.valid = grant;
        rsp_d.data  = grant & {N_CPU{old_val}};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_data  = rsp_q.data;

    AST_RSP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(rsp_valid)); // R9
    AST_RSP_TO_REQUESTER: assert property (@(posedge clk) disable iff (!rst_n)
        (|rsp_d.valid) |=> (|(rsp_valid & $past(req_valid)))); // R9
    AST_DATA_ONLY_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        ((rsp_data & ~rsp_valid) == '0)); // R9

endmodule

// File: tb/sem_unit_bench.sv
module sem_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int N_CPU      = 4;
    localparam int N_SEM      = 16;
    localparam int IDX_W      = 4;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic [N_CPU-1:0]       req_valid = '0;
    logic [2*N_CPU-1:0]     req_op = '0;
    logic [N_CPU*IDX_W-1:0] req_idx = '0;
    logic [N_CPU-1:0]       rsp_valid;
    logic [N_CPU-1:0]       rsp_data;

    int checks = 0;
    int fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sem_unit #(.N_CPU(N_CPU), .N_SEM(N_SEM), .IDX_W(IDX_W)) u_sem_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_idx   (req_idx),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    typedef struct packed {
        logic [1:0] cpu;
        logic [1:0] op;
        logic [3:0] idx;
        logic       exp;
    } vec_t;

    // op codes: 00 read, 01 test-and-set, 10 clear, 11 spare
    localparam vec_t VECS [14] = '{
        '{2'd0, 2'b00, 4'd3,  1'b0},  // R6 read free
        '{2'd1, 2'b01, 4'd3,  1'b0},  // R2 claim
        '{2'd2, 2'b01, 4'd3,  1'b1},  // R3 claim busy
        '{2'd3, 2'b00, 4'd3,  1'b1},  // R6 still busy
        '{2'd0, 2'b00, 4'd4,  1'b0},  // R10 neighbour untouched
        '{2'd1, 2'b10, 4'd3,  1'b1},  // R4 release
        '{2'd2, 2'b00, 4'd3,  1'b0},  // R4 now free
        '{2'd3, 2'b10, 4'd3,  1'b0},  // R5 release free
        '{2'd0, 2'b11, 4'd3,  1'b0},  // R7 spare on free
        '{2'd0, 2'b01, 4'd15, 1'b0},  // R10 top index claim
        '{2'd1, 2'b11, 4'd15, 1'b1},  // R7 spare on busy
        '{2'd2, 2'b00, 4'd15, 1'b1},  // R7 spare left it busy
        '{2'd3, 2'b00, 4'd14, 1'b0},  // R10 below top untouched
        '{2'd1, 2'b00, 4'd3,  1'b0}   // R7 spare left it free
    };

    function automatic string tag_of(input logic [1:0] op, input logic exp);
        case (op)
            2'b00:   return "R6";
            2'b01:   return exp ? "R3" : "R2";
            2'b10:   return exp ? "R4" : "R5";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input logic ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_req(input int cpu, input logic [1:0] op, input logic [3:0] idx);
        req_valid[cpu]             = 1'b1;
        req_op[cpu*2 +: 2]         = op;
        req_idx[cpu*IDX_W +: IDX_W] = idx;
    endtask

    // one lane, one op: drive at negedge, response visible at next negedge
    task automatic single_op(input int cpu, input logic [1:0] op, input logic [3:0] idx,
                             input logic exp, input string tag);
        put_req(cpu, op, idx);
        @(posedge clk); @(negedge clk);
        check(rsp_valid == N_CPU'(1 << cpu), tag, 32'(rsp_valid), 32'(1 << cpu));
        check(rsp_data[cpu] == exp, tag, 32'(rsp_data[cpu]), 32'(exp));
        req_valid[cpu] = 1'b0;
        @(posedge clk); @(negedge clk);
        check(rsp_valid == '0, "R9", 32'(rsp_valid), 32'h0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check(rsp_valid == '0, "R1", 32'(rsp_valid), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check(rsp_valid == '0, "R1", 32'(rsp_valid), 32'h0);

        // R1: every semaphore clear after reset
        for (int s = 0; s < N_SEM; s++) begin
            single_op(0, 2'b00, 4'(s), 1'b0, "R1");
        end

        // table walk
        for (int v = 0; v < 14; v++) begin
            single_op(int'(VECS[v].cpu), VECS[v].op, VECS[v].idx, VECS[v].exp,
                      tag_of(VECS[v].op, VECS[v].exp));
        end

        // R8: four lanes race test-and-set on free semaphore 5
        for (int c = 0; c < N_CPU; c++) put_req(c, 2'b01, 4'd5);
        for (int c = 0; c < N_CPU; c++) begin
            @(posedge clk); @(negedge clk);
            check(rsp_valid == N_CPU'(1 << c), "R8", 32'(rsp_valid), 32'(1 << c));
            check(rsp_data[c] == (c != 0), "R8", 32'(rsp_data[c]), 32'(c != 0));
            req_valid[c] = 1'b0;
        end
        @(posedge clk); @(negedge clk);
        check(rsp_valid == '0, "R9", 32'(rsp_valid), 32'h0);
        single_op(0, 2'b10, 4'd5, 1'b1, "R4");

        // R8: lanes 3 and 2 race on different semaphores, lane 2 first
        put_req(3, 2'b01, 4'd6);
        put_req(2, 2'b01, 4'd7);
        @(posedge clk); @(negedge clk);
        check(rsp_valid == 4'b0100, "R8", 32'(rsp_valid), 32'h4);
        check(rsp_data[2] == 1'b0, "R2", 32'(rsp_data[2]), 32'h0);
        req_valid[2] = 1'b0;
        @(posedge clk); @(negedge clk);
        check(rsp_valid == 4'b1000, "R8", 32'(rsp_valid), 32'h8);
        check(rsp_data[3] == 1'b0, "R2", 32'(rsp_data[3]), 32'h0);
        req_valid[3] = 1'b0;
        @(posedge clk); @(negedge clk);
        check(rsp_valid == '0, "R9", 32'(rsp_valid), 32'h0);
        single_op(1, 2'b00, 4'd6, 1'b1, "R10");
        single_op(1, 2'b00, 4'd7, 1'b1, "R10");
        single_op(1, 2'b00, 4'd8, 1'b0, "R10");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule